// File: doc/BRIEF.md
# Root Clock Generator with Fractional Divider

This block derives a clock-enable stream from one of several source clocks. The sources reach it as single-cycle tick strobes in the system clock domain. A pre-divider turns the selected tick stream into pulses at a half-integer ratio. An optional M/N:D stage then thins those pulses to an average of M out of every N. The same stage drives a level output whose duty cycle is set by D. The block has two outputs: `clk_en`, a pulse train, and `clk_lvl`, a duty-shaped level.

Software writes a shadow copy of the settings through a 32-bit register port. The settings become active only after software sets a commit bit. That bit stays at 1 until the new settings have been swapped in at the next output pulse, and then it clears itself. In table mode, eight stored performance levels each hold their own settings. The `lvl_sel` input chooses among them, and a change of level also takes effect at the next output pulse.

Top module: `clk_root_gen`

## Requirements
- R1: After reset the commit bit (address 0, bit 0) reads 0 and the table-control register (address 5) reads 0x8000. The active settings are source 0 with no division, so `clk_en` pulses once for every tick of source 0.
- R2: Writes to the shadow registers (address 1 settings, 2 M, 3 N, 4 D) read back at once but do not change the output until a commit.
- R3: Writing 1 to bit 0 of address 0 makes that bit read 1. The bit clears on the same clock edge at which the new settings take over. That edge is the one that produces the next `clk_en` pulse, so while the selected source is silent the bit stays at 1.
- R4: The divide field sits at bits [4:0] of the settings word. A value F other than 0 gives one output per (F+1)/2 ticks (2 gives 1.5, 3 gives 2, 5 gives 3). F = 0 is treated as divide by 1.
- R5: The source field sits at bits [10:8] and picks bit k of `src_tick`. While the selected source does not tick, `clk_en` stays low.
- R6: When the mode field (bits [13:12]) equals 2 and M is not zero, `clk_en` gives M pulses for every N pre-divided ticks. The N register holds the low 16 bits of the inverse of (N−M), and the D register holds the low 16 bits of the inverse of 2·D.
- R7: When M is zero, or the mode field is not 2, the fractional stage is bypassed and `clk_en` equals the pre-divider output.
- R8: With the fractional stage active, `clk_lvl` is high while twice the accumulator value is below 2·D; with M = 1 this is D of every N ticks. With the stage bypassed, `clk_lvl` equals `clk_en`.
- R9: Writing address 5 with bit 0 set enters table mode and forces bit 15 (software control) to 0. Level i keeps its settings at address 8+i, M at 16+i, N at 24+i and D at 32+i, in the same encodings as the shadow registers.
- R10: In table mode the entry selected by `lvl_sel` replaces the active settings at the next `clk_en` pulse after the selection differs from the active level. Until then the old settings run.
- R11: In table mode, writes to the commit bit are ignored and it reads 0.
- R12: `clk_en` is high only in a cycle that follows a cycle in which some source ticked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_tick | input | NSRC | One tick strobe per source clock |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| lvl_sel | input | log2(NLVL) | Performance level selected in table mode |
| clk_en | output | 1 | Generated clock-enable pulse |
| clk_lvl | output | 1 | Duty-cycle shaped level |

## Verification
The bench counts pulses over windows whose length is a whole number of output periods. A wrong half-integer step, for example treating a field value of 2 as divide by 2, shows up as a wrong count, and so does an N or D value decoded without the inversion. It holds one source silent while a commit or a level change is pending. A design that swaps settings at once, instead of at the next pulse, would clear the commit bit early or start pulsing early. It also checks that entering table mode drops the software-control bit and blocks the commit bit. A design that missed this would keep a stale pending commit.

// File: rtl/clk_root_gen.sv
module clk_root_gen #(
  parameter int NSRC   = 4,
  parameter int DIV_W  = 5,
  parameter int MND_W  = 16,
  parameter int NLVL   = 8,
  parameter int ADDR_W = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NSRC-1:0]         src_tick,
  input  logic                    reg_we,
  input  logic [ADDR_W-1:0]       reg_addr,
  input  logic [31:0]             reg_wdata,
  output logic [31:0]             reg_rdata,
  input  logic [$clog2(NLVL)-1:0] lvl_sel,
  output logic                    clk_en,
  output logic                    clk_lvl
);
  localparam int LW    = $clog2(NLVL);
  localparam int CFG_W = 14;
  localparam logic [CFG_W-1:0] CFG_MASK = CFG_W'((1 << DIV_W) - 1) | 14'h3700;

  logic upd_q, dfs_en, sw_ctl;
  logic [CFG_W-1:0] s_cfg;
  logic [MND_W-1:0] s_m, s_n, s_d;
  logic [CFG_W-1:0] t_cfg [NLVL];
  logic [MND_W-1:0] t_m [NLVL];
  logic [MND_W-1:0] t_n [NLVL];
  logic [MND_W-1:0] t_d [NLVL];

  logic [DIV_W-1:0] a_div;
  logic [2:0]       a_src;
  logic [1:0]       a_mode;
  logic [MND_W-1:0] a_m, a_n, a_dd;
  logic             act_dfs;
  logic [LW-1:0]    act_lvl;
  logic [DIV_W:0]   pacc, pacc_nx;
  logic [MND_W-1:0] acc, acc_nx;

  wire [ADDR_W-LW-1:0] grp = reg_addr[ADDR_W-1:LW];
  wire [LW-1:0]        idx = reg_addr[LW-1:0];
  logic unused_wd;
  assign unused_wd = ^reg_wdata;

  logic [CFG_W-1:0] p_cfg;
  logic [MND_W-1:0] p_m, p_n, p_d;
  always_comb begin
    if (dfs_en) begin
      p_cfg = t_cfg[lvl_sel]; p_m = t_m[lvl_sel]; p_n = t_n[lvl_sel]; p_d = t_d[lvl_sel];
    end else begin
      p_cfg = s_cfg; p_m = s_m; p_n = s_n; p_d = s_d;
    end
  end

  logic [7:0] tick_vec;
  always_comb begin
    tick_vec = '0;
    tick_vec[NSRC-1:0] = src_tick;
  end
  wire tick = tick_vec[a_src];

  wire [DIV_W:0]   plim = {1'b0, a_div} + 1'b1;
  wire [DIV_W+1:0] psum = {1'b0, pacc} + 2'd2;
  logic pre;
  always_comb begin
    pre = 1'b0;
    pacc_nx = pacc;
    if (a_div == '0) begin
      pre = tick;
    end else if (tick) begin
      if (psum >= {1'b0, plim}) begin
        pre = 1'b1;
        pacc_nx = (DIV_W+1)'(psum - {1'b0, plim});
      end else begin
        pacc_nx = psum[DIV_W:0];
      end
    end
  end

  wire             mnd_on = (a_mode == 2'd2) && (a_m != '0);
  wire [MND_W:0]   msum   = {1'b0, acc} + {1'b0, a_m};
  wire             wrap   = msum >= {1'b0, a_n};
  wire             en_nx  = mnd_on ? (pre && wrap) : pre;
  always_comb begin
    acc_nx = acc;
    if (mnd_on && pre) acc_nx = wrap ? MND_W'(msum - {1'b0, a_n}) : msum[MND_W-1:0];
  end
  wire lvl_nx = mnd_on ? ({1'b0, acc_nx, 1'b0} < {2'b00, a_dd}) : en_nx;

  wire swap = en_nx && (dfs_en ? (!act_dfs || act_lvl != lvl_sel) : upd_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_q <= 1'b0; dfs_en <= 1'b0; sw_ctl <= 1'b1;
      s_cfg <= '0; s_m <= '0; s_n <= '0; s_d <= '0;
      for (int i = 0; i < NLVL; i++) begin
        t_cfg[i] <= '0; t_m[i] <= '0; t_n[i] <= '0; t_d[i] <= '0;
      end
    end else begin
      if (swap && !dfs_en) upd_q <= 1'b0;
      if (reg_we) begin
        case (int'(grp))
          0: case (int'(idx))
               0: if (reg_wdata[0] && !dfs_en) upd_q <= 1'b1;
               1: s_cfg <= reg_wdata[CFG_W-1:0] & CFG_MASK;
               2: s_m <= reg_wdata[MND_W-1:0];
               3: s_n <= reg_wdata[MND_W-1:0];
               4: s_d <= reg_wdata[MND_W-1:0];
               5: begin
                 dfs_en <= reg_wdata[0];
                 sw_ctl <= reg_wdata[0] ? 1'b0 : reg_wdata[15];
                 if (reg_wdata[0]) upd_q <= 1'b0;
               end
               default: ;
             endcase
          1: t_cfg[idx] <= reg_wdata[CFG_W-1:0] & CFG_MASK;
          2: t_m[idx] <= reg_wdata[MND_W-1:0];
          3: t_n[idx] <= reg_wdata[MND_W-1:0];
          4: t_d[idx] <= reg_wdata[MND_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_div <= '0; a_src <= '0; a_mode <= '0;
      a_m <= '0; a_n <= '0; a_dd <= '0;
      act_dfs <= 1'b0; act_lvl <= '0;
      pacc <= '0; acc <= '0;
      clk_en <= 1'b0; clk_lvl <= 1'b0;
    end else begin
      if (swap) begin
        a_div   <= p_cfg[DIV_W-1:0];
        a_src   <= p_cfg[10:8];
        a_mode  <= p_cfg[13:12];
        a_m     <= p_m;
        a_n     <= ~p_n + p_m;
        a_dd    <= ~p_d;
        act_dfs <= dfs_en;
        act_lvl <= lvl_sel;
        pacc    <= '0;
        acc     <= '0;
      end else begin
        pacc <= pacc_nx;
        acc  <= acc_nx;
      end
      clk_en  <= en_nx;
      clk_lvl <= lvl_nx;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (int'(grp))
      0: case (int'(idx))
           0: reg_rdata = {31'b0, upd_q};
           1: reg_rdata = 32'(s_cfg);
           2: reg_rdata = 32'(s_m);
           3: reg_rdata = 32'(s_n);
           4: reg_rdata = 32'(s_d);
           5: reg_rdata = {16'b0, sw_ctl, 14'b0, dfs_en};
           default: ;
         endcase
      1: reg_rdata = 32'(t_cfg[idx]);
      2: reg_rdata = 32'(t_m[idx]);
      3: reg_rdata = 32'(t_n[idx]);
      4: reg_rdata = 32'(t_d[idx]);
      default: ;
    endcase
  end
endmodule

module clk_root_gen_chk #(
  parameter int NSRC  = 4,
  parameter int DIV_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NSRC-1:0]  src_tick,
  input logic             clk_en,
  input logic             upd_q,
  input logic             dfs_en,
  input logic             sw_ctl,
  input logic [DIV_W-1:0] a_div,
  input logic             mnd_on
);
  // R12
  en_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en |-> $past(|src_tick));
  // R3
  upd_clear_on_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(upd_q) && !dfs_en) |-> clk_en);
  // R9
  dfs_drops_sw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dfs_en) |-> !sw_ctl);
  // R11
  dfs_blocks_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dfs_en |-> !upd_q);
  // R4
  half_div_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_div == DIV_W'(3) && !mnd_on && clk_en) |=> !clk_en);
endmodule

bind clk_root_gen clk_root_gen_chk #(.NSRC(NSRC), .DIV_W(DIV_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .clk_en(clk_en),
  .upd_q(upd_q), .dfs_en(dfs_en), .sw_ctl(sw_ctl), .a_div(a_div), .mnd_on(mnd_on)
);

// File: tb/clk_root_gen_tb.sv
`timescale 1ns/1ps
module clk_root_gen_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [5:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [2:0] lvl_sel = '0;
  logic clk_en, clk_lvl;
  logic [2:0] gen_tick = '0;
  logic man_tick = 1'b0;
  logic [3:0] src_tick;
  int cyc = 0;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  assign src_tick = {man_tick, gen_tick};
  always #2 clk = ~clk;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    gen_tick[0] <= 1'b1;
    gen_tick[1] <= cyc[0];
    gen_tick[2] <= (cyc % 8 == 0);
  end

  clk_root_gen dut_i (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .lvl_sel(lvl_sel), .clk_en(clk_en), .clk_lvl(clk_lvl)
  );

  function automatic logic [31:0] nenc(int n, int m);
    return 32'((~(n - m)) & 16'hFFFF);
  endfunction
  function automatic logic [31:0] denc(int d);
    return 32'((~(2 * d)) & 16'hFFFF);
  endfunction

  task automatic check(string tag, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 6'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(int a, output int v);
    reg_addr = 6'(a);
    #1 v = int'(reg_rdata);
  endtask

  task automatic count(int n, bit lvl, output int c);
    c = 0;
    repeat (n) begin
      @(negedge clk);
      c += lvl ? int'(clk_lvl) : int'(clk_en);
    end
  endtask

  task automatic commit(logic [31:0] cfg, int m, int n, int d);
    wr(1, cfg); wr(2, 32'(m)); wr(3, nenc(n, m)); wr(4, denc(d));
    wr(0, 1);
    repeat (12) @(negedge clk);
  endtask

  task automatic pulse_man();
    @(negedge clk) man_tick = 1'b1;
    @(negedge clk) man_tick = 1'b0;
  endtask

  task automatic t_reset();
    int v;
    rd(0, v); check("R1 commit bit", v, 0);
    rd(5, v); check("R1 table ctl", v, 32'h8000);
    count(20, 0, v); check("R1 pulses", v, 20);
  endtask

  task automatic t_shadow();
    int v;
    wr(1, 3);
    rd(1, v); check("R2 readback", v, 3);
    count(20, 0, v); check("R2 no effect", v, 20);
  endtask

  task automatic t_commit();
    int v;
    wr(0, 1);
    rd(0, v); check("R3 pending", v, 1);
    repeat (3) @(negedge clk);
    rd(0, v); check("R3 self clear", v, 0);
    count(40, 0, v); check("R4 div 2", v, 20);
  endtask

  task automatic t_div();
    int v;
    commit(2, 0, 0, 0); count(60, 0, v); check("R4 div 1.5", v, 40);
    commit(0, 0, 0, 0); count(60, 0, v); check("R4 bypass", v, 60);
    commit(5, 0, 0, 0); count(60, 0, v); check("R4 div 3", v, 20);
  endtask

  task automatic t_src();
    int v;
    commit((1 << 8) | 1, 0, 0, 0); count(60, 0, v); check("R5 src1", v, 30);
    commit((2 << 8) | 1, 0, 0, 0); count(64, 0, v); check("R5 src2", v, 8);
  endtask

  task automatic t_mnd();
    int v;
    commit((2 << 12) | 1, 1, 3, 1); count(60, 0, v); check("R6 1/3", v, 20);
    commit((2 << 12) | 1, 2, 5, 1); count(60, 0, v); check("R6 2/5", v, 24);
    commit((2 << 12) | 1, 0, 3, 1); count(60, 0, v); check("R7 m zero", v, 60);
    commit(1, 1, 3, 1);             count(60, 0, v); check("R7 mode off", v, 60);
  endtask

  task automatic t_duty();
    int v;
    commit((2 << 12) | 1, 1, 4, 2); count(40, 1, v); check("R8 duty 2/4", v, 20);
    count(40, 0, v); check("R6 1/4", v, 10);
    commit((2 << 12) | 1, 1, 4, 1); count(40, 1, v); check("R8 duty 1/4", v, 10);
    commit(3, 0, 0, 0);             count(40, 1, v); check("R8 bypass lvl", v, 20);
  endtask

  task automatic t_wait();
    int v;
    commit((3 << 8) | 1, 0, 0, 0);
    count(20, 0, v); check("R5 silent source", v, 0);
    wr(1, 1); wr(0, 1);
    count(20, 0, v); check("R3 no early swap", v, 0);
    rd(0, v); check("R3 still pending", v, 1);
    pulse_man();
    #1;
    check("R3 pulse at swap", int'(clk_en), 1);
    rd(0, v); check("R3 clear at swap", v, 0);
    count(20, 0, v); check("R3 new cfg", v, 20);
  endtask

  task automatic t_dfs();
    int v;
    wr(8, 1);                wr(16, 0); wr(24, 0);         wr(32, 0);
    wr(9, 3);                wr(17, 0); wr(25, 0);         wr(33, 0);
    wr(10, (2 << 12) | 1);   wr(18, 1); wr(26, nenc(3, 1)); wr(34, denc(1));
    wr(11, (3 << 8) | 1);    wr(19, 0); wr(27, 0);         wr(35, 0);
    rd(26, v); check("R9 table readback", v, int'(nenc(3, 1)));
    lvl_sel = 3'd1;
    wr(5, 32'h8001);
    rd(5, v); check("R9 sw bit cleared", v, 1);
    repeat (12) @(negedge clk);
    count(60, 0, v); check("R9 level 1", v, 30);
    lvl_sel = 3'd2;
    repeat (12) @(negedge clk);
    count(60, 0, v); check("R10 level 2", v, 20);
    wr(0, 1);
    rd(0, v); check("R11 commit ignored", v, 0);
    lvl_sel = 3'd3;
    repeat (12) @(negedge clk);
    count(20, 0, v); check("R10 level 3 silent", v, 0);
    lvl_sel = 3'd0;
    count(20, 0, v); check("R10 waits for pulse", v, 0);
    pulse_man();
    #1;
    check("R10 pulse at swap", int'(clk_en), 1);
    repeat (5) @(negedge clk);
    count(30, 0, v); check("R10 level 0", v, 30);
    wr(5, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_shadow();
    t_commit();
    t_div();
    t_src();
    t_mnd();
    t_duty();
    t_wait();
    t_dfs();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule